// File: doc/BRIEF.md
# Page ECC Status Evaluator

This block runs once a full-page read with hardware error correction has finished. It takes a bank of 32-bit status words that hold packed 4-bit error counts, one per 512-byte sector. It walks the sectors that belong to the selected page buffer, one sector per clock. For each sector it adds the count to a corrected-bit total and keeps the largest count seen. The count value 15 means the sector could not be corrected.

When a sector reports 15, the walk stops and the block scans the page buffer to decide whether the page is simply erased. The scan reads every 32-bit word of the main area, then the words of the spare area that hold ECC bytes. The uncorrectable flag is raised only when some scanned word is not all-ones. Buffer reads leave the block as a valid/ready request stream. The request holds its address while ready is low. Only one request is outstanding at a time, and the response comes back on a valid strobe that the block always accepts.

When the evaluation ends, `done` pulses for one cycle. The corrected total, the maximum flips and the flag then hold their values until the next evaluation begins.

Top module: `ecc_page_evaluator`

## Requirements
- R1: An evaluation begins only when `start` is high with `full_read` high while the block is idle. A `start` with `full_read` low produces no `done`, no buffer read and no change on any output.
- R2: With S = `steps`, the sectors evaluated run from `buf_num`×S up to `buf_num`×S+S−1 in ascending order, one per cycle. When no sector reports 15, `done` rises S cycles after the clock edge that captured `start`.
- R3: The count for sector s is taken from status word s/4, which sits at `stat_words[(s/4)*32 +: 32]`. Inside that word, the count occupies bits [(3−s%4)×8 +: 4], so sector 0 of a word uses bits 27:24. All other bits are ignored.
- R4: `corr_total` equals the sum of the counts of the sectors evaluated before the first sector that reports 15.
- R5: `max_flips` is the largest count among those same sectors. It is cleared to 0 at the start of each evaluation.
- R6: A count of 15 ends the sector walk. Later sectors of the page add nothing to either output.
- R7: After a count of 15, the erased scan reads the following words:
  - the main area: S×128 words starting at word address `buf_num`×S×256;
  - the ECC words of the spare area: starting 2 words past the end of the main area, S×2 words when `ecc_wide`=0 and S×4 words when `ecc_wide`=1.
  
  `uncorr` is 1 if any scanned word differs from 0xFFFFFFFF, and 0 otherwise.
- R8: The scan stops at the first word that is not all-ones. The number of read requests accepted in an evaluation is the position of that word plus one, or the full scan length when the page is erased. No read occurs when no sector reports 15.
- R9: While `rd_req_valid` is high and `rd_req_ready` is low, the request stays valid and `rd_req_addr` stays unchanged. No new request is raised while a response is pending.
- R10: After reset, `corr_total`, `max_flips`, `uncorr`, `done` and `rd_req_valid` are all 0.
- R11: `done` is high for exactly one cycle per evaluation. The results hold until the next evaluation starts.
- R12: `uncorr` returns to 0 when the next evaluation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Evaluation request pulse |
| full_read | input | 1 | Marks that the finished read was a full-page corrected read |
| ecc_wide | input | 1 | 1: 16 ECC bytes per sector, 0: 8 bytes |
| buf_num | input | BUF_W | Page buffer number |
| steps | input | STEPS_W | Sectors per page (1 to MAX_STEPS) |
| stat_words | input | NSTAT_WORDS×32 | Packed per-sector error-count words |
| rd_req_valid | output | 1 | Buffer read request valid |
| rd_req_ready | input | 1 | Buffer read request accepted |
| rd_req_addr | output | ADDR_W | Buffer word address |
| rd_resp_valid | input | 1 | Read data valid |
| rd_resp_data | input | 32 | Read data word |
| corr_total | output | CORR_W | Corrected bit total |
| max_flips | output | 4 | Largest correctable sector count |
| uncorr | output | 1 | Uncorrectable, non-erased page |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume four things about the inputs:
- `buf_num`×`steps`+`steps` never exceeds the number of sectors in the status bank.
- `steps` is between 1 and MAX_STEPS.
- Each read response arrives one or more cycles after its request was accepted.
- `start` is not raised while an evaluation is in progress.

The stimulus holds to all four. Every vector picks a buffer and sector count that fit within 16 sectors, and the memory model answers exactly one cycle after each accepted request. `start` is raised only after `done` has been seen. The memory model stalls `rd_req_ready` one cycle in eight, so the rule that a request holds while stalled is exercised on every scan.

// File: rtl/ecc_eval_pkg.sv
package ecc_eval_pkg;

  typedef enum logic [1:0] {
    EV_IDLE = 2'd0,
    EV_SECT = 2'd1,
    EV_SCAN = 2'd2
  } ev_state_t;

  typedef enum logic [1:0] {
    SC_IDLE = 2'd0,
    SC_REQ  = 2'd1,
    SC_RESP = 2'd2
  } sc_state_t;

  localparam logic [3:0] CNT_UNCORR = 4'hF;
  localparam logic [31:0] ERASED_WORD = 32'hFFFF_FFFF;

endpackage

// File: rtl/sector_field_pick.sv
module sector_field_pick #(
  parameter int NSTAT_WORDS = 4,
  localparam int NSECT  = NSTAT_WORDS * 4,
  localparam int SECT_W = $clog2(NSECT)
) (
  input  logic [NSTAT_WORDS*32-1:0] stat_words,
  input  logic [SECT_W-1:0]         sect,
  output logic [3:0]                count
);

  logic [3:0] fields [NSECT];

  for (genvar g = 0; g < NSECT; g++) begin : g_fld
    // sector g: word g/4, highest byte for g%4 == 0
    assign fields[g] = stat_words[(g/4)*32 + (3 - (g%4))*8 +: 4];
  end

  assign count = fields[sect];

endmodule

// File: rtl/sector_accum.sv
module sector_accum #(
  parameter int CORR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              add_en,
  input  logic [3:0]        count,
  output logic [CORR_W-1:0] corr_total,
  output logic [3:0]        max_flips
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      corr_total <= '0;
      max_flips  <= '0;
    end else if (clear) begin
      corr_total <= '0;
      max_flips  <= '0;
    end else if (add_en) begin
      corr_total <= corr_total + CORR_W'(count);
      if (count > max_flips) max_flips <= count;
    end
  end

endmodule

// File: rtl/page_blank_scanner.sv
module page_blank_scanner
  import ecc_eval_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int CNT_W     = 11,
  parameter int OOB_OFS_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic [ADDR_W-1:0] base_addr,
  input  logic [CNT_W-1:0]  main_words,
  input  logic [CNT_W-1:0]  ecc_words,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [ADDR_W-1:0] req_addr,
  input  logic              resp_valid,
  input  logic [31:0]       resp_data,
  output logic              fin,
  output logic              blank
);

  sc_state_t        st;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] total;
  logic [CNT_W-1:0] off;

  assign total = main_words + ecc_words;

  always_comb begin
    if (idx < main_words) off = idx;
    else off = main_words + CNT_W'(OOB_OFS_W) + (idx - main_words);
  end

  assign req_valid = (st == SC_REQ);
  assign req_addr  = base_addr + ADDR_W'(off);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= SC_IDLE;
      idx   <= '0;
      fin   <= 1'b0;
      blank <= 1'b0;
    end else begin
      fin <= 1'b0;
      unique case (st)
        SC_IDLE: begin
          if (go) begin
            idx <= '0;
            st  <= SC_REQ;
          end
        end
        SC_REQ: begin
          if (req_ready) st <= SC_RESP;
        end
        SC_RESP: begin
          if (resp_valid) begin
            if (resp_data != ERASED_WORD) begin
              fin   <= 1'b1;
              blank <= 1'b0;
              st    <= SC_IDLE;
            end else if (idx == total - CNT_W'(1)) begin
              fin   <= 1'b1;
              blank <= 1'b1;
              st    <= SC_IDLE;
            end else begin
              idx <= idx + CNT_W'(1);
              st  <= SC_REQ;
            end
          end
        end
        default: st <= SC_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecc_page_evaluator.sv
module ecc_page_evaluator
  import ecc_eval_pkg::*;
#(
  parameter int NSTAT_WORDS     = 4,
  parameter int MAX_STEPS       = 8,
  parameter int BUF_W           = 4,
  parameter int ADDR_W          = 16,
  parameter int SECTOR_BYTES    = 512,
  parameter int ECC_OOB_OFS     = 8,
  parameter int ECC_BYTES_NARROW = 8,
  parameter int ECC_BYTES_WIDE  = 16,
  localparam int STEPS_W = $clog2(MAX_STEPS + 1),
  localparam int CORR_W  = 4 + $clog2(MAX_STEPS + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic                     full_read,
  input  logic                     ecc_wide,
  input  logic [BUF_W-1:0]         buf_num,
  input  logic [STEPS_W-1:0]       steps,
  input  logic [NSTAT_WORDS*32-1:0] stat_words,
  output logic                     rd_req_valid,
  input  logic                     rd_req_ready,
  output logic [ADDR_W-1:0]        rd_req_addr,
  input  logic                     rd_resp_valid,
  input  logic [31:0]              rd_resp_data,
  output logic [CORR_W-1:0]        corr_total,
  output logic [3:0]               max_flips,
  output logic                     uncorr,
  output logic                     done
);

  localparam int NSECT     = NSTAT_WORDS * 4;
  localparam int SECT_W    = $clog2(NSECT);
  localparam int PROD_W    = BUF_W + STEPS_W;
  localparam int MAIN_WPS  = SECTOR_BYTES / 4;
  localparam int ECC_WPS_N = ECC_BYTES_NARROW / 4;
  localparam int ECC_WPS_W = ECC_BYTES_WIDE / 4;
  localparam int OOB_OFS_W = ECC_OOB_OFS / 4;
  localparam int SCAN_MAX  = MAX_STEPS * (MAIN_WPS + ECC_WPS_W) + OOB_OFS_W;
  localparam int CNT_W     = $clog2(SCAN_MAX + 1);

  ev_state_t        st;
  logic [SECT_W-1:0] sect_q, last_q;
  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  main_q, ecc_q;
  logic              scan_go;
  logic              scan_fin, scan_blank;
  logic [3:0]        cur_count;
  logic              accept;
  logic              acc_clear, acc_add;

  // page geometry, computed from the inputs at capture time
  logic [PROD_W-1:0] first_sect;
  logic [PROD_W-1:0] last_sect;
  logic [ADDR_W-1:0] base_words;
  logic [CNT_W-1:0]  main_words;
  logic [CNT_W-1:0]  ecc_words;

  assign first_sect = PROD_W'(buf_num) * PROD_W'(steps);
  assign last_sect  = first_sect + PROD_W'(steps) - PROD_W'(1);
  assign base_words = ADDR_W'(first_sect) * ADDR_W'(2 * MAIN_WPS);
  assign main_words = CNT_W'(steps) * CNT_W'(MAIN_WPS);
  assign ecc_words  = CNT_W'(steps) * (ecc_wide ? CNT_W'(ECC_WPS_W) : CNT_W'(ECC_WPS_N));

  assign accept    = (st == EV_IDLE) && start && full_read;
  assign acc_clear = accept;
  assign acc_add   = (st == EV_SECT) && (cur_count != CNT_UNCORR);

  sector_field_pick #(
    .NSTAT_WORDS(NSTAT_WORDS)
  ) u_pick (
    .stat_words(stat_words),
    .sect      (sect_q),
    .count     (cur_count)
  );

  sector_accum #(
    .CORR_W(CORR_W)
  ) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .clear     (acc_clear),
    .add_en    (acc_add),
    .count     (cur_count),
    .corr_total(corr_total),
    .max_flips (max_flips)
  );

  page_blank_scanner #(
    .ADDR_W   (ADDR_W),
    .CNT_W    (CNT_W),
    .OOB_OFS_W(OOB_OFS_W)
  ) u_scan (
    .clk       (clk),
    .rst_n     (rst_n),
    .go        (scan_go),
    .base_addr (base_q),
    .main_words(main_q),
    .ecc_words (ecc_q),
    .req_valid (rd_req_valid),
    .req_ready (rd_req_ready),
    .req_addr  (rd_req_addr),
    .resp_valid(rd_resp_valid),
    .resp_data (rd_resp_data),
    .fin       (scan_fin),
    .blank     (scan_blank)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= EV_IDLE;
      sect_q  <= '0;
      last_q  <= '0;
      base_q  <= '0;
      main_q  <= '0;
      ecc_q   <= '0;
      scan_go <= 1'b0;
      uncorr  <= 1'b0;
      done    <= 1'b0;
    end else begin
      done    <= 1'b0;
      scan_go <= 1'b0;
      unique case (st)
        EV_IDLE: begin
          if (accept) begin
            sect_q <= SECT_W'(first_sect);
            last_q <= SECT_W'(last_sect);
            base_q <= base_words;
            main_q <= main_words;
            ecc_q  <= ecc_words;
            uncorr <= 1'b0;
            st     <= EV_SECT;
          end
        end
        EV_SECT: begin
          if (cur_count == CNT_UNCORR) begin
            scan_go <= 1'b1;
            st      <= EV_SCAN;
          end else if (sect_q == last_q) begin
            done <= 1'b1;
            st   <= EV_IDLE;
          end else begin
            sect_q <= sect_q + SECT_W'(1);
          end
        end
        EV_SCAN: begin
          if (scan_fin) begin
            uncorr <= ~scan_blank;
            done   <= 1'b1;
            st     <= EV_IDLE;
          end
        end
        default: st <= EV_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/ecc_page_evaluator_chk.sv
module ecc_page_evaluator_chk #(
  parameter int ADDR_W = 16,
  parameter int CORR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              full_read,
  input logic              done,
  input logic              uncorr,
  input logic [3:0]        max_flips,
  input logic [CORR_W-1:0] corr_total,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr
);

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_req_addr)); // R9

  AST_MAX_WITHIN_TOTAL: assert property (@(posedge clk) disable iff (!rst_n)
    (CORR_W'(max_flips) <= corr_total) && (max_flips != 4'hF)); // R5

  AST_UNCORR_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(uncorr) |-> done); // R7

  AST_UNCORR_CLEAR_ON_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(uncorr) |-> $past(start && full_read)); // R12

endmodule

bind ecc_page_evaluator ecc_page_evaluator_chk #(
  .ADDR_W(ADDR_W),
  .CORR_W(CORR_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .full_read   (full_read),
  .done        (done),
  .uncorr      (uncorr),
  .max_flips   (max_flips),
  .corr_total  (corr_total),
  .rd_req_valid(rd_req_valid),
  .rd_req_ready(rd_req_ready),
  .rd_req_addr (rd_req_addr)
);

// File: tb/ecc_page_evaluator_bench.sv
`timescale 1ns/1ps
module ecc_page_evaluator_bench;

  localparam logic [16:0] NONE = 17'h1_0000;

  typedef struct packed {
    logic [127:0] stat;
    logic [3:0]   bnum;
    logic [3:0]   steps;
    logic         wide;
    logic [16:0]  poison;
    logic [7:0]   corr;
    logic [3:0]   maxf;
    logic         unc;
    logic [11:0]  reads;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VECS [NV] = '{
    // R3: sector 0 in top byte of word 0
    '{ {96'h0, 32'h0102_0300}, 4'd0, 4'd4, 1'b0, NONE, 8'd6, 4'd3, 1'b0, 12'd0 },
    // R3: upper nibbles ignored, word 1 for buffer 1
    '{ {64'h0, 32'h3EF0_A571, 32'h0}, 4'd1, 4'd4, 1'b0, NONE, 8'd20, 4'd14, 1'b0, 12'd0 },
    // R6: code 15 at sector 1 stops the walk; erased page, full scan
    '{ {64'h0, 32'h0, 32'h020F_0909}, 4'd0, 4'd8, 1'b0, NONE, 8'd2, 4'd2, 1'b0, 12'd1040 },
    // R8: non-erased main word 5 stops scan after 6 reads
    '{ {64'h0, 32'h0, 32'h020F_0909}, 4'd0, 4'd8, 1'b0, 17'd5, 8'd2, 4'd2, 1'b1, 12'd6 },
    // R7: wide ECC, last spare ECC word (777) dirty
    '{ {96'h0, 32'h0000_0F03}, 4'd1, 4'd2, 1'b1, 17'd777, 8'd0, 4'd0, 1'b1, 12'd264 },
    // R7/R12: dirty word just past ECC region is not read; flag clears
    '{ {96'h0, 32'h0000_0F03}, 4'd1, 4'd2, 1'b1, 17'd778, 8'd0, 4'd0, 1'b0, 12'd264 },
    // R7: code 15 on last sector; word before base is not read
    '{ {32'h0404_040F, 96'h0}, 4'd3, 4'd4, 1'b0, 17'd3071, 8'd12, 4'd4, 1'b0, 12'd520 },
    // R2: sectors 8..15 across words 2 and 3
    '{ {32'h0102_0107, 32'h0101_0101, 64'h0}, 4'd1, 4'd8, 1'b0, NONE, 8'd15, 4'd7, 1'b0, 12'd0 }
  };

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         full_read = 1'b0;
  logic         ecc_wide = 1'b0;
  logic [3:0]   buf_num = '0;
  logic [3:0]   steps = 4'd1;
  logic [127:0] stat_words = '0;
  logic         rd_req_valid;
  logic         rd_req_ready;
  logic [15:0]  rd_req_addr;
  logic         rd_resp_valid;
  logic [31:0]  rd_resp_data;
  logic [7:0]   corr_total;
  logic [3:0]   max_flips;
  logic         uncorr;
  logic         done;

  logic [16:0]  poison = NONE;
  logic [2:0]   rdy_cnt;
  int           reads;
  int           viol;
  logic         prev_stall;
  logic [15:0]  prev_addr;
  int           checks = 0;
  int           fails = 0;
  bit           finished = 1'b0;

  always #4 clk = ~clk;

  ecc_page_evaluator u_ecc_page_evaluator (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .full_read    (full_read),
    .ecc_wide     (ecc_wide),
    .buf_num      (buf_num),
    .steps        (steps),
    .stat_words   (stat_words),
    .rd_req_valid (rd_req_valid),
    .rd_req_ready (rd_req_ready),
    .rd_req_addr  (rd_req_addr),
    .rd_resp_valid(rd_resp_valid),
    .rd_resp_data (rd_resp_data),
    .corr_total   (corr_total),
    .max_flips    (max_flips),
    .uncorr       (uncorr),
    .done         (done)
  );

  // buffer model: stalls one cycle in eight, answers one cycle after accept
  assign rd_req_ready = (rdy_cnt != 3'd0);

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_cnt       <= 3'd0;
      rd_resp_valid <= 1'b0;
      rd_resp_data  <= '0;
      reads         <= 0;
      viol          <= 0;
      prev_stall    <= 1'b0;
      prev_addr     <= '0;
    end else begin
      rdy_cnt       <= rdy_cnt + 3'd1;
      rd_resp_valid <= rd_req_valid && rd_req_ready;
      rd_resp_data  <= ({1'b0, rd_req_addr} == poison) ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
      if (rd_req_valid && rd_req_ready) reads <= reads + 1;
      if (prev_stall && (!rd_req_valid || rd_req_addr != prev_addr)) viol <= viol + 1;
      if (rd_resp_valid && rd_req_valid) viol <= viol + 1;
      prev_stall <= rd_req_valid && !rd_req_ready;
      prev_addr  <= rd_req_addr;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_vec(input int i);
    vec_t v;
    int   r0;
    int   cyc;
    v = VECS[i];
    @(negedge clk);
    stat_words = v.stat;
    buf_num    = v.bnum;
    steps      = v.steps;
    ecc_wide   = v.wide;
    poison     = v.poison;
    full_read  = 1'b1;
    r0         = reads;
    start      = 1'b1;
    @(negedge clk);
    start = 1'b0;
    full_read = 1'b0;
    cyc = 0;
    while (!done && cyc < 6000) begin
      @(negedge clk);
      cyc++;
    end
    chk(done, "R11 done seen", int'(done), 1);
    chk(corr_total == v.corr, "R4 corrected total", int'(corr_total), int'(v.corr));
    chk(max_flips == v.maxf, "R5 max flips", int'(max_flips), int'(v.maxf));
    chk(uncorr == v.unc, "R7/R12 uncorrectable", int'(uncorr), int'(v.unc));
    chk((reads - r0) == int'(v.reads), "R8 reads issued", reads - r0, int'(v.reads));
    if (v.reads == 12'd0)
      chk(cyc == int'(v.steps), "R2 cycles to done", cyc, int'(v.steps));
    @(negedge clk);
    chk(!done, "R11 done one cycle", int'(done), 0);
  endtask

  initial begin
    int   r0;
    bit   seen;
    logic [7:0] c0;
    logic [3:0] m0;
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(corr_total == 8'd0, "R10 corr after reset", int'(corr_total), 0);
    chk(max_flips == 4'd0, "R10 max after reset", int'(max_flips), 0);
    chk(!uncorr, "R10 uncorr after reset", int'(uncorr), 0);
    chk(!done, "R10 done after reset", int'(done), 0);
    chk(!rd_req_valid, "R10 no request after reset", int'(rd_req_valid), 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(i);

    // R1: start without the full-read flag is ignored
    c0 = corr_total;
    m0 = max_flips;
    r0 = reads;
    stat_words = {32'h0F0F_0F0F, 96'h0};
    buf_num = 4'd3;
    steps = 4'd4;
    @(negedge clk);
    start = 1'b1;
    full_read = 1'b0;
    @(negedge clk);
    start = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen, "R1 no done without flag", int'(seen), 0);
    chk(corr_total == c0, "R1 total unchanged", int'(corr_total), int'(c0));
    chk(max_flips == m0, "R1 max unchanged", int'(max_flips), int'(m0));
    chk(!uncorr, "R1 uncorr unchanged", int'(uncorr), 0);
    chk(reads == r0, "R1 no reads", reads, r0);

    // R12: a dirty page sets the flag, the next clean evaluation clears it
    run_vec(3);
    run_vec(0);

    // R9: request held under stall, no overlap with pending response
    chk(viol == 0, "R9 request protocol", viol, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule